// File: doc/BRIEF.md
# SPI Master Register and FIFO Front-End

This block sits between a 32-bit register bus and the serial shifting engine of an SPI master. It decodes five word registers: control/status, a FIFO data port, a clock divider, a transfer length and a DMA threshold word. It owns two byte-wide FIFOs, one for transmit and one for receive, and it presents the run bit, the clock mode, the chip-select choice and the divider to the engine. The engine pops transmit bytes, pushes receive bytes and reports whether it is busy. From these the block derives its status flags and a level-sensitive interrupt.

The FIFO port changes meaning with the run bit. While no transfer is active, a word written to the FIFO port loads the transfer length from its upper half and the low control byte from its lowest byte. A DMA engine can therefore program the mode and start a frame with one write. While a transfer is active, the same write pushes a byte into the transmit FIFO. A frame-end pulse from the DMA side stops the transfer.

Bus reads are combinational: `bus_rdata` is valid in the cycle the read is presented. A read of the FIFO port pops the receive FIFO on the next clock edge.

Top module: `spi_regfront`

## Requirements
- R1: After reset the control word reads 0x0004_1000: run (bit 7), clock polarity (bit 3), clock phase (bit 2) and every chip-select polarity are 0, read-enable (bit 12) is 1 and room-in-TX (bit 18) is 1. The divider (0x08) and length (0x0C) read 0. The threshold word (0x14) reads 0x3020_1020.
- R2: With run at 1, a write to the FIFO port (0x04) pushes its bits 7:0 into the TX FIFO. The engine sees those bytes in write order on `tx_byte` while `tx_valid` is 1. The length register is left unchanged.
- R3: With run at 0, a write to the FIFO port loads bits 31:16 into the length register and bits 7:0 into control bits 7:0. The TX FIFO is left unchanged.
- R4: Control bit 4 written as 1 empties the TX FIFO. Control bit 5 written as 1 empties the RX FIFO. Both bits always read back 0.
- R5: A single control write that sets bit 4, bit 5 and run empties both FIFOs and leaves run at 1. No stale byte is offered to the engine afterwards.
- R6: Needs-reading (bit 19) is 1 only while run is 1 and the RX FIFO holds at least three quarters of its depth (48 of 64 bytes).
- R7: Done (bit 16) is 1 only while run is 1, the TX FIFO is empty and `eng_busy` is 0. Writing a TX byte clears it.
- R8: Has-data (bit 17) is 1 while the RX FIFO holds at least one byte. Full (bit 20, and port `rx_full`) is 1 while the RX FIFO holds 64 bytes. Room-in-TX (bit 18) is 0 only when the TX FIFO holds 64 bytes.
- R9: `irq` is 1 while (bit 10 and needs-reading) or (bit 9 and done) holds, so it is 0 whenever run is 0.
- R10: A one-cycle `frame_end` pulse clears run. It takes priority over a control write in the same cycle.
- R11: Reading the FIFO port while the RX FIFO is empty returns 0 and changes no state.
- R12: A push into a full FIFO (from the bus for TX, or from the engine for RX) is dropped. The bytes already stored are kept and read out in order.
- R13: The divider register stores bits 15:0 and the threshold register stores all 32 bits of a write. Both read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Run is 1 and a TX byte is waiting |
| tx_byte | output | 8 | Head of the TX FIFO |
| tx_pop | input | 1 | Engine takes the head byte |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_full | output | 1 | RX FIFO full; the engine should pause |
| eng_busy | input | 1 | Engine is shifting a byte |
| frame_end | input | 1 | DMA frame-end pulse, clears run |
| run | output | 1 | Transfer active |
| cpol | output | 1 | Clock idle level |
| cpha | output | 1 | Clock phase select |
| cs_sel | output | 2 | Selected chip-select line |
| cs_pol_all | output | 1 | Common chip-select polarity |
| cs_pol_line | output | 3 | Per-line chip-select polarity |
| ren | output | 1 | Read-enable for bidirectional use |
| dma_en | output | 1 | DMA mode enable |
| clk_div | output | 16 | Serial clock divider |
| xfer_len | output | 16 | Transfer length in bytes |
| dma_thresh | output | 32 | DMA threshold word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the needs-reading and full edge of the RX FIFO while the transmit side is idle. The bench drives the engine's push port directly, one byte per call, to step the RX FIFO across 47, 48 and 64 entries. It then pushes one more byte than the FIFO holds, so the dropped byte shows up in the drained sequence if it were kept. The redirection of FIFO-port writes is also awkward, because the same address acts two ways depending on run. The bench therefore issues that write first with run at 0 and then with run at 1, checking the length register and the engine-side byte stream each time. The bench also sets clear and run in one control write while both FIFOs hold bytes.

// File: rtl/spi_regfront.sv
module spi_regfront #(
  parameter int          DEPTH    = 64,
  parameter logic [31:0] DC_RESET = 32'h3020_1020
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  input  logic        tx_pop,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  output logic        rx_full,
  input  logic        eng_busy,
  input  logic        frame_end,
  output logic        run,
  output logic        cpol,
  output logic        cpha,
  output logic [1:0]  cs_sel,
  output logic        cs_pol_all,
  output logic [2:0]  cs_pol_line,
  output logic        ren,
  output logic        dma_en,
  output logic [15:0] clk_div,
  output logic [15:0] xfer_len,
  output logic [31:0] dma_thresh,
  output logic        irq
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = AW + 1;
  localparam int RXR_LVL = (3 * DEPTH) / 4;
  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_FIFO = 5'h04;
  localparam logic [4:0] A_DIV  = 5'h08;
  localparam logic [4:0] A_LEN  = 5'h0C;
  localparam logic [4:0] A_DC   = 5'h14;

  logic          int_done_en, int_rx_en;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_ctrl = bus_valid & bus_write & (bus_addr == A_CTRL);
  wire wr_fifo = bus_valid & bus_write & (bus_addr == A_FIFO);
  wire rd_fifo = bus_valid & ~bus_write & (bus_addr == A_FIFO);
  wire ctl_load = wr_ctrl | (wr_fifo & ~run);
  wire clr_tx = ctl_load & bus_wdata[4];
  wire clr_rx = ctl_load & bus_wdata[5];

  wire tx_empty = (tx_cnt == '0);
  wire tx_full  = (tx_cnt == CW'(DEPTH));
  wire rx_empty = (rx_cnt == '0);
  wire rxf      = (rx_cnt == CW'(DEPTH));

  wire push_tx = wr_fifo & run & ~tx_full;
  wire pop_tx  = tx_pop & tx_valid;
  wire push_rx = rx_push & ~rxf;
  wire pop_rx  = rd_fifo & ~rx_empty;

  wire st_done = run & tx_empty & ~eng_busy;
  wire st_rxr  = run & (rx_cnt >= CW'(RXR_LVL));

  assign tx_valid = run & ~tx_empty;
  assign tx_byte  = tx_mem[tx_rp];
  assign rx_full  = rxf;
  assign irq      = (int_rx_en & st_rxr) | (int_done_en & st_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run         <= 1'b0;
      cpol        <= 1'b0;
      cpha        <= 1'b0;
      cs_sel      <= 2'd0;
      cs_pol_all  <= 1'b0;
    end else begin
      if (ctl_load) begin
        cs_sel     <= bus_wdata[1:0];
        cpha       <= bus_wdata[2];
        cpol       <= bus_wdata[3];
        cs_pol_all <= bus_wdata[6];
      end
      if (frame_end)     run <= 1'b0;
      else if (ctl_load) run <= bus_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_en      <= 1'b0;
      int_done_en <= 1'b0;
      int_rx_en   <= 1'b0;
      ren         <= 1'b1;
      cs_pol_line <= 3'd0;
      clk_div     <= 16'd0;
      xfer_len    <= 16'd0;
      dma_thresh  <= DC_RESET;
    end else begin
      if (wr_ctrl) begin
        dma_en      <= bus_wdata[8];
        int_done_en <= bus_wdata[9];
        int_rx_en   <= bus_wdata[10];
        ren         <= bus_wdata[12];
        cs_pol_line <= bus_wdata[23:21];
      end
      if (wr_fifo & ~run)
        xfer_len <= bus_wdata[31:16];
      if (bus_valid & bus_write & (bus_addr == A_LEN))
        xfer_len <= bus_wdata[15:0];
      if (bus_valid & bus_write & (bus_addr == A_DIV))
        clk_div <= bus_wdata[15:0];
      if (bus_valid & bus_write & (bus_addr == A_DC))
        dma_thresh <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else if (clr_tx) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (push_tx) tx_wp <= tx_wp + 1'b1;
      if (pop_tx)  tx_rp <= tx_rp + 1'b1;
      if (push_tx & ~pop_tx)      tx_cnt <= tx_cnt + 1'b1;
      else if (pop_tx & ~push_tx) tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else if (clr_rx) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (push_rx) rx_wp <= rx_wp + 1'b1;
      if (pop_rx)  rx_rp <= rx_rp + 1'b1;
      if (push_rx & ~pop_rx)      rx_cnt <= rx_cnt + 1'b1;
      else if (pop_rx & ~push_rx) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_tx) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (push_rx) rx_mem[rx_wp] <= rx_byte;
  end

  always_comb begin
    bus_rdata = 32'd0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[1:0]   = cs_sel;
        bus_rdata[2]     = cpha;
        bus_rdata[3]     = cpol;
        bus_rdata[6]     = cs_pol_all;
        bus_rdata[7]     = run;
        bus_rdata[8]     = dma_en;
        bus_rdata[9]     = int_done_en;
        bus_rdata[10]    = int_rx_en;
        bus_rdata[12]    = ren;
        bus_rdata[16]    = st_done;
        bus_rdata[17]    = ~rx_empty;
        bus_rdata[18]    = ~tx_full;
        bus_rdata[19]    = st_rxr;
        bus_rdata[20]    = rxf;
        bus_rdata[23:21] = cs_pol_line;
      end
      A_FIFO:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_mem[rx_rp]};
      A_DIV:   bus_rdata = {16'd0, clk_div};
      A_LEN:   bus_rdata = {16'd0, xfer_len};
      A_DC:    bus_rdata = dma_thresh;
      default: bus_rdata = 32'd0;
    endcase
  end

  p_idle_write_keeps_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fifo && !run && !bus_wdata[4] && !pop_tx) |=> $stable(tx_cnt));

  p_clear_tx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_load && bus_wdata[4]) |=> !tx_valid);

  p_push_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fifo && run && !tx_full && !frame_end) |=> !st_done);

  p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !irq);

  p_frame_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !run);

  p_rx_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf && rx_push && !pop_rx && !clr_rx) |=> (rxf && $stable(rx_wp)));
endmodule

// File: tb/spi_regfront_tb.sv
module spi_regfront_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;
  // {write, addr, data, expected, requirement}
  localparam logic [73:0] VEC [NV] = '{
    {1'b0, 5'h00, 32'h0, 32'h0004_1000, 4'd1},   // R1
    {1'b0, 5'h08, 32'h0, 32'h0000_0000, 4'd1},   // R1
    {1'b0, 5'h14, 32'h0, 32'h3020_1020, 4'd1},   // R1
    {1'b0, 5'h0C, 32'h0, 32'h0000_0000, 4'd1},   // R1
    {1'b1, 5'h04, 32'h0005_0089, 32'h0, 4'd3},   // R3 idle FIFO write
    {1'b0, 5'h0C, 32'h0, 32'h0000_0005, 4'd3},   // R3
    {1'b0, 5'h00, 32'h0, 32'h0005_1089, 4'd3},   // R3
    {1'b1, 5'h04, 32'h0000_00A5, 32'h0, 4'd2},   // R2 active FIFO write
    {1'b0, 5'h00, 32'h0, 32'h0004_1089, 4'd7},   // R7 done cleared
    {1'b0, 5'h0C, 32'h0, 32'h0000_0005, 4'd2},   // R2 length kept
    {1'b1, 5'h00, 32'h0000_1099, 32'h0, 4'd4},   // R4 clear TX
    {1'b0, 5'h00, 32'h0, 32'h0005_1089, 4'd4},   // R4
    {1'b1, 5'h08, 32'h0001_0010, 32'h0, 4'd13},  // R13
    {1'b0, 5'h08, 32'h0, 32'h0000_0010, 4'd13},  // R13
    {1'b1, 5'h14, 32'h0102_0304, 32'h0, 4'd13},  // R13
    {1'b0, 5'h14, 32'h0, 32'h0102_0304, 4'd13},  // R13
    {1'b1, 5'h00, 32'h0000_1000, 32'h0, 4'd7},   // R7
    {1'b0, 5'h00, 32'h0, 32'h0004_1000, 4'd7}    // R7 done forced 0
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_pop = 1'b0, rx_push = 1'b0, rx_full, eng_busy = 1'b0, frame_end = 1'b0;
  logic [7:0] tx_byte, rx_byte = '0;
  logic run, cpol, cpha, cs_pol_all, ren, dma_en, irq;
  logic [1:0] cs_sel;
  logic [2:0] cs_pol_line;
  logic [15:0] clk_div, xfer_len;
  logic [31:0] dma_thresh, rd;
  int checks = 0, errors = 0;

  spi_regfront u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_valid = 1'b0;
  endtask

  task automatic rx_in(input logic [7:0] b);
    @(negedge clk); rx_push = 1'b1; rx_byte = b;
    @(posedge clk); #1 rx_push = 1'b0;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_pop = 1'b1;
    @(posedge clk); #1 tx_pop = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1'b1;
    @(negedge clk);
    check("R1 ren", {31'd0, ren}, 32'd1);
    check("R1 run", {31'd0, run}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][73]) wr(VEC[i][72:68], VEC[i][67:36]);
      else begin
        rdreg(VEC[i][72:68], rd);
        check($sformatf("R%0d row %0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end
    end

    // R2 ordering to the engine
    wr(5'h04, 32'h0000_1080); // idle FIFO write: run=1
    wr(5'h04, 32'h11); wr(5'h04, 32'h22); wr(5'h04, 32'h33);
    check("R2 length unchanged", {16'd0, xfer_len}, 32'h0000_0000);
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      check("R2 tx byte", {23'd0, tx_valid, tx_byte}, {23'd0, 1'b1, 8'(i * 8'h11)});
      tx_take();
    end
    @(negedge clk);
    check("R2 tx drained", {31'd0, tx_valid}, 32'd0);

    // R7 busy engine holds done low
    eng_busy = 1'b1;
    rdreg(5'h00, rd); check("R7 busy", {31'd0, rd[16]}, 32'd0);
    eng_busy = 1'b0;
    rdreg(5'h00, rd); check("R7 done", {31'd0, rd[16]}, 32'd1);

    // R11 empty read
    rdreg(5'h04, rd); check("R11 empty read", rd, 32'd0);
    rdreg(5'h00, rd); check("R11 rxd stays 0", {31'd0, rd[17]}, 32'd0);

    // R6 R8 R9 R12 receive fill
    wr(5'h00, 32'h0000_1480);
    for (int i = 0; i < 47; i++) rx_in(8'(i));
    rdreg(5'h00, rd); check("R6 below level", {30'd0, rd[19], rd[17]}, 32'd1);
    rx_in(8'd47);
    rdreg(5'h00, rd); check("R6 at level", {31'd0, rd[19]}, 32'd1);
    @(negedge clk); check("R9 irq on rx level", {31'd0, irq}, 32'd1);
    for (int i = 48; i < 64; i++) rx_in(8'(i));
    rdreg(5'h00, rd); check("R8 full flag", {30'd0, rd[20], rx_full}, 32'd3);
    rx_in(8'hEE);
    wr(5'h00, 32'h0000_1400);
    rdreg(5'h00, rd); check("R6 forced low idle", {31'd0, rd[19]}, 32'd0);
    @(negedge clk); check("R9 irq idle", {31'd0, irq}, 32'd0);
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        rdreg(5'h04, rd);
        if (rd !== 32'(i)) bad++;
      end
      check("R12 rx order, overflow dropped", bad, 0);
    end
    rdreg(5'h04, rd); check("R12 no extra byte", rd, 32'd0);
    rdreg(5'h00, rd); check("R8 rxd clear", {31'd0, rd[17]}, 32'd0);

    // R9 done interrupt
    wr(5'h00, 32'h0000_1280);
    @(negedge clk); check("R9 irq on done", {31'd0, irq}, 32'd1);
    wr(5'h04, 32'h55);
    @(negedge clk); check("R9 irq drops on data", {31'd0, irq}, 32'd0);
    tx_take();
    @(negedge clk); check("R9 irq back", {31'd0, irq}, 32'd1);

    // R5 clear with start
    wr(5'h00, 32'h0000_1080);
    wr(5'h04, 32'h77); wr(5'h04, 32'h78);
    rx_in(8'h01); rx_in(8'h02);
    wr(5'h00, 32'h0000_1000);
    rdreg(5'h00, rd); check("R5 fifos hold", {31'd0, rd[17]}, 32'd1);
    wr(5'h00, 32'h0000_10B0);
    rdreg(5'h00, rd); check("R5 cleared and running", rd, 32'h0005_1080);
    @(negedge clk); check("R5 no stale tx", {31'd0, tx_valid}, 32'd0);

    // R12 TX full
    for (int i = 0; i < 64; i++) wr(5'h04, 32'(i));
    rdreg(5'h00, rd); check("R8 tx full", {31'd0, rd[18]}, 32'd0);
    wr(5'h04, 32'hEE);
    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) begin
        @(negedge clk);
        if (!tx_valid || tx_byte !== 8'(i)) bad++;
        tx_take();
      end
      check("R12 tx order, overflow dropped", bad, 0);
    end
    @(negedge clk); check("R12 tx empty", {31'd0, tx_valid}, 32'd0);

    // R10 frame end beats a control write
    @(negedge clk); frame_end = 1'b1; bus_valid = 1'b1; bus_write = 1'b1;
    bus_addr = 5'h00; bus_wdata = 32'h0000_1080;
    @(posedge clk); #1 frame_end = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    rdreg(5'h00, rd); check("R10 run cleared", {31'd0, rd[7]}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule